// File: doc/BRIEF.md
# Rotate-and-mask shift unit

This block is the shift and rotate execution unit of a 64-bit integer datapath. Each cycle it can accept one operation. The operation is given by a 4-bit select code. Its inputs are a source operand, an insert-target operand, a shift amount and a pair of mask boundary fields. The shift amount comes either from a register-sourced 7-bit field or from a 6-bit immediate. The arithmetic work is purely combinational. A two-state output stage captures the result and a carry flag, and presents them one cycle later.

The output stage has two named states. `ST_IDLE` means no result is on offer. `ST_PRESENT` means the registered result is valid. The state register has three transitions:
- `load` (any state to `ST_PRESENT`) is taken when `in_valid` is high.
- `drain` (`ST_PRESENT` to `ST_IDLE`) is taken when `in_valid` is low.
- `rest` (`ST_IDLE` to `ST_IDLE`) is taken when `in_valid` stays low.

Reset forces `ST_IDLE`. The result and carry registers load only on `load`, so they hold their values in every other cycle.

Mask boundaries use big-endian numbering: index 0 names the most significant bit. When the begin index is greater than the end index, the mask wraps around. Word rotates work on a 64-bit value built from the low word placed in both halves. Word mask indices are offset by 32 inside the 64-bit mask.

Top module: `rotmask_unit`

## Requirements
- R1: Op 0 (word rotate-and-mask): the low word is placed in both halves and rotated left by amount mod 32. The 64-bit mask is set on big-endian bits (32+mb[4:0])..(32+me[4:0]), where big-endian bit i is result bit 63-i. The result is the rotate ANDed with the mask.
- R2: Op 1 (word rotate-insert) uses the same rotate and mask as R1. Where the mask is 1, the result takes the rotated bit. Elsewhere it keeps the bit of `tgt`.
- R3: Op 2 (doubleword rotate, clear left) keeps big-endian bits mb..63 of the 64-bit rotate by amount[5:0]. Op 3 (doubleword rotate, clear right) keeps big-endian bits 0..me.
- R4: Op 4 (doubleword rotate, clear both) uses the mask big-endian mb..(63-amount[5:0]).
- R5: When the mask begin index is greater than the end index, the mask covers begin..63 and 0..end. With op 0, for example, the bits outside the word show the duplicated word.
- R6: Op 5 and op 6 are word logical left and right shifts on the low word, zero-extended to 64 bits. They use amount[5:0]. An amount of 32 or more gives 0.
- R7: Op 7 and op 8 are doubleword logical left and right shifts. They use the 7-bit amount. An amount of 64 or more gives 0, and an amount of 0 returns `src` unchanged.
- R8: Op 9 is a word arithmetic right shift by amount[5:0]. The 32-bit result is sign-extended to 64 bits, and an amount of 32 or more gives all sign bits. `carry` is 1 only when the word is negative and at least one 1 bit was shifted out. Every other op gives carry 0.
- R9: Op 10 sign-extends the low word to 64 bits, then shifts it left by amount[5:0].
- R10: The amount is `{1'b0, imm_sh}` when `use_imm` is 1, and `rb_amt` otherwise.
- R11: `out_valid` is 1 exactly in the cycle after an `in_valid` cycle. Reset clears `out_valid`, `result` and `carry`. Without `in_valid`, `result` and `carry` hold their values.
- R12: Op codes 11 to 15 give result 0 and carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation select code |
| src | input | 64 | Source operand |
| tgt | input | 64 | Insert-target operand |
| rb_amt | input | 7 | Register-sourced shift amount |
| imm_sh | input | 6 | Immediate shift amount |
| use_imm | input | 1 | Select immediate amount |
| mb | input | 6 | Mask begin index (big-endian) |
| me | input | 6 | Mask end index (big-endian) |
| out_valid | output | 1 | Registered result valid |
| result | output | 64 | Registered result |
| carry | output | 1 | Registered arithmetic-shift carry |

## Verification
The checker watches the output stage on every cycle. It checks that `out_valid` follows `in_valid` by one cycle and that `result` and `carry` stay put between loads. It also checks that carry stays 0 for every op other than the arithmetic shift. The out-of-range fills are checked the same way: a zero result for a doubleword shift of 64 or more, and all sign bits for an arithmetic word shift of 32 or more. The mask arithmetic needs the bench's scenarios to show it, because only a reference model can tell whether a given wrap, insert or clear boundary landed on the right bit. Those scenarios are the directed examples, wrapped masks, amount-source selection and random operands.

// File: rtl/rm_pkg.sv
package rm_pkg;
    typedef enum logic [3:0] {
        OP_RLW_AND = 4'd0,
        OP_RLW_INS = 4'd1,
        OP_RLD_CL  = 4'd2,
        OP_RLD_CR  = 4'd3,
        OP_RLD_C   = 4'd4,
        OP_SLW     = 4'd5,
        OP_SRW     = 4'd6,
        OP_SLD     = 4'd7,
        OP_SRD     = 4'd8,
        OP_SRAW    = 4'd9,
        OP_EXTSH   = 4'd10
    } rm_op_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } rm_state_e;
endpackage

// File: rtl/rm_mask_gen.sv
module rm_mask_gen #(
    parameter int XLEN = 64
) (
    input  logic [$clog2(XLEN)-1:0] mask_begin,
    input  logic [$clog2(XLEN)-1:0] mask_end,
    output logic [XLEN-1:0]         mask
);
    localparam int IW = $clog2(XLEN);

    logic wraps;
    assign wraps = mask_begin > mask_end;

    // Big-endian index i drives little-endian bit XLEN-1-i.
    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        localparam logic [IW-1:0] IDX = IW'(i);
        assign mask[XLEN-1-i] = wraps ? ((IDX >= mask_begin) || (IDX <= mask_end))
                                      : ((IDX >= mask_begin) && (IDX <= mask_end));
    end
endmodule

// File: rtl/rm_rotl.sv
module rm_rotl #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]         din,
    input  logic [$clog2(XLEN)-1:0] amt,
    output logic [XLEN-1:0]         dout
);
    localparam int IW = $clog2(XLEN);

    logic [XLEN-1:0] stg [0:IW];
    assign stg[0] = din;

    for (genvar s = 0; s < IW; s++) begin : g_stage
        localparam int SH = 1 << s;
        assign stg[s+1] = amt[s] ? {stg[s][XLEN-1-SH:0], stg[s][XLEN-1:XLEN-SH]}
                                 : stg[s];
    end

    assign dout = stg[IW];
endmodule

// File: rtl/rm_shift_core.sv
module rm_shift_core
    import rm_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [3:0]              op,
    input  logic [XLEN-1:0]         src,
    input  logic [XLEN-1:0]         tgt,
    input  logic [$clog2(XLEN):0]   amt,
    input  logic [$clog2(XLEN)-1:0] mb,
    input  logic [$clog2(XLEN)-1:0] me,
    output logic [XLEN-1:0]         res,
    output logic                    carry
);
    localparam int IW  = $clog2(XLEN);
    localparam int WL  = XLEN / 2;
    localparam int WIW = IW - 1;

    rm_op_e opc;
    assign opc = rm_op_e'(op);

    logic [WL-1:0] word;
    assign word = src[WL-1:0];

    logic word_rot;
    assign word_rot = (opc == OP_RLW_AND) || (opc == OP_RLW_INS);

    logic [XLEN-1:0] rot_in, rot_out, mask;
    logic [IW-1:0]   rot_amt, m_begin, m_end;

    assign rot_in  = word_rot ? {word, word} : src;
    assign rot_amt = word_rot ? {1'b0, amt[WIW-1:0]} : amt[IW-1:0];

    always_comb begin
        m_begin = mb;
        m_end   = me;
        unique case (opc)
            OP_RLW_AND, OP_RLW_INS: begin
                m_begin = {1'b1, mb[WIW-1:0]};
                m_end   = {1'b1, me[WIW-1:0]};
            end
            OP_RLD_CL: m_end   = {IW{1'b1}};
            OP_RLD_CR: m_begin = '0;
            OP_RLD_C:  m_end   = ~amt[IW-1:0];
            default: ;
        endcase
    end

    rm_rotl #(.XLEN(XLEN)) u_rot (
        .din  (rot_in),
        .amt  (rot_amt),
        .dout (rot_out)
    );

    rm_mask_gen #(.XLEN(XLEN)) u_mask (
        .mask_begin (m_begin),
        .mask_end   (m_end),
        .mask       (mask)
    );

    logic              w_big;
    logic [WIW-1:0]    w_sh;
    logic signed [WL-1:0] w_signed, w_sra;
    logic [WL-1:0]     w_lost;

    assign w_big    = amt[IW-1];
    assign w_sh     = amt[WIW-1:0];
    assign w_signed = signed'(word);
    assign w_sra    = w_signed >>> w_sh;
    assign w_lost   = w_big ? word : (word & ~({WL{1'b1}} << w_sh));

    always_comb begin
        res   = '0;
        carry = 1'b0;
        unique case (opc)
            OP_RLW_AND, OP_RLD_CL, OP_RLD_CR, OP_RLD_C: res = rot_out & mask;
            OP_RLW_INS: res = (rot_out & mask) | (tgt & ~mask);
            OP_SLW:     res = w_big ? '0 : {{WL{1'b0}}, word << w_sh};
            OP_SRW:     res = w_big ? '0 : {{WL{1'b0}}, word >> w_sh};
            OP_SLD:     res = amt[IW] ? '0 : src << amt[IW-1:0];
            OP_SRD:     res = amt[IW] ? '0 : src >> amt[IW-1:0];
            OP_SRAW: begin
                res   = w_big ? {XLEN{word[WL-1]}} : {{WL{w_sra[WL-1]}}, w_sra};
                carry = word[WL-1] && (w_lost != '0);
            end
            OP_EXTSH:   res = {{WL{word[WL-1]}}, word} << amt[IW-1:0];
            default: begin
                res   = '0;
                carry = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
    import rm_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int IW  = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [3:0]      op,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] tgt,
    input  logic [IW:0]     rb_amt,
    input  logic [IW-1:0]   imm_sh,
    input  logic            use_imm,
    input  logic [IW-1:0]   mb,
    input  logic [IW-1:0]   me,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic            carry
);
    logic [IW:0]     amt;
    logic [XLEN-1:0] core_res;
    logic            core_carry;

    assign amt = use_imm ? {1'b0, imm_sh} : rb_amt;

    rm_shift_core #(.XLEN(XLEN)) u_core (
        .op    (op),
        .src   (src),
        .tgt   (tgt),
        .amt   (amt),
        .mb    (mb),
        .me    (me),
        .res   (core_res),
        .carry (core_carry)
    );

    rm_state_e state, state_nxt;

    always_comb begin
        unique case (state)
            ST_IDLE:    state_nxt = in_valid ? ST_PRESENT : ST_IDLE;
            ST_PRESENT: state_nxt = in_valid ? ST_PRESENT : ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            carry  <= 1'b0;
        end else if (in_valid) begin
            result <= core_res;
            carry  <= core_carry;
        end
    end

    assign out_valid = (state == ST_PRESENT);
endmodule

// File: rtl/rotmask_unit_chk.sv
module rotmask_unit_chk #(
    parameter int XLEN = 64,
    localparam int IW  = $clog2(XLEN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [3:0]      op,
    input logic [XLEN-1:0] src,
    input logic [IW:0]     rb_amt,
    input logic [IW-1:0]   imm_sh,
    input logic            use_imm,
    input logic            out_valid,
    input logic [XLEN-1:0] result,
    input logic            carry
);
    logic [IW:0] n_chk;
    assign n_chk = use_imm ? {1'b0, imm_sh} : rb_amt;

    // R11: valid follows the request by one cycle
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r11_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(carry)));
    // R8: carry only from the arithmetic word shift
    a_r8_carry_source: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != 4'd9) |=> !carry);
    // R8: out-of-range arithmetic shift fills with the sign
    a_r8_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd9 && n_chk[IW-1]) |=> (result == {XLEN{$past(src[XLEN/2-1])}}));
    // R7: doubleword shift of 64 or more is zero
    a_r7_big_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 4'd7 || op == 4'd8) && n_chk[IW]) |=> (result == '0));
endmodule

bind rotmask_unit rotmask_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .src       (src),
    .rb_amt    (rb_amt),
    .imm_sh    (imm_sh),
    .use_imm   (use_imm),
    .out_valid (out_valid),
    .result    (result),
    .carry     (carry)
);

// File: tb/sim_rotmask_unit.sv
`timescale 1ns/1ps
module sim_rotmask_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [63:0] src = '0, tgt = '0;
    logic [6:0]  rb_amt = '0;
    logic [5:0]  imm_sh = '0, mb = '0, me = '0;
    logic        use_imm = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        carry;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    rotmask_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .src(src),
        .tgt(tgt), .rb_amt(rb_amt), .imm_sh(imm_sh), .use_imm(use_imm),
        .mb(mb), .me(me), .out_valid(out_valid), .result(result), .carry(carry)
    );

    function automatic logic [63:0] f_rotl(input logic [63:0] x, input int k);
        logic [63:0] r = x;
        for (int i = 0; i < k; i++) r = {r[62:0], r[63]};
        return r;
    endfunction

    function automatic logic [63:0] f_mask(input int b, input int e);
        logic [63:0] m = '0;
        for (int i = 0; i < 64; i++)
            if ((b <= e) ? (i >= b && i <= e) : (i >= b || i <= e)) m[63-i] = 1'b1;
        return m;
    endfunction

    function automatic void f_ref(input logic [3:0] o, input logic [63:0] s,
                                  input logic [63:0] t, input int n, input int b,
                                  input int e, output logic [63:0] r, output logic c);
        logic [31:0] w = s[31:0];
        logic [63:0] rw, m, sx;
        int n6 = n % 64;
        r = '0; c = 1'b0;
        rw = f_rotl({w, w}, n % 32);
        sx = {{32{w[31]}}, w};
        case (o)
            4'd0: r = rw & f_mask(32 + b % 32, 32 + e % 32);
            4'd1: begin m = f_mask(32 + b % 32, 32 + e % 32); r = (rw & m) | (t & ~m); end
            4'd2: r = f_rotl(s, n6) & f_mask(b, 63);
            4'd3: r = f_rotl(s, n6) & f_mask(0, e);
            4'd4: r = f_rotl(s, n6) & f_mask(b, 63 - n6);
            4'd5: r = (n6 >= 32) ? 64'd0 : {32'd0, w << n6};
            4'd6: r = (n6 >= 32) ? 64'd0 : {32'd0, w >> n6};
            4'd7: r = (n >= 64) ? 64'd0 : s << n;
            4'd8: r = (n >= 64) ? 64'd0 : s >> n;
            4'd9: begin
                for (int i = 0; i < 64; i++) r[i] = (i + n6 < 32) ? w[i + n6] : w[31];
                for (int i = 0; i < 32; i++) if (i < n6 && w[i]) c = w[31];
            end
            4'd10: r = sx << n6;
            default: r = '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%016h expected 0x%016h", req, got, exp);
        end
    endtask

    task automatic issue(input logic [3:0] o, input logic [63:0] s, input logic [63:0] t,
                         input int n, input bit imm, input int b, input int e);
        @(negedge clk);
        op = o; src = s; tgt = t; use_imm = imm;
        imm_sh = 6'(n); rb_amt = 7'(n); mb = 6'(b); me = 6'(e);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run(input string req, input logic [3:0] o, input logic [63:0] s,
                       input logic [63:0] t, input int n, input bit imm, input int b,
                       input int e, input logic [63:0] exp, input logic expc);
        issue(o, s, t, n, imm, b, e);
        check(req, {63'd0, out_valid}, 64'd1);
        check(req, result, exp);
        check(req, {63'd0, carry}, {63'd0, expc});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] er, hold;
        logic ec;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset valid", {63'd0, out_valid}, 64'd0);
        check("R11 reset result", result, 64'd0);
        rst_n = 1'b1;

        run("R1", 4'd0, 64'h8fffffff, 0, 1, 1, 31, 31, 64'h1, 0);
        run("R1", 4'd0, 64'hf1110001, 0, 1, 1, 0, 30, 64'he2220002, 0);
        run("R1 reg amt", 4'd0, 64'hfebaacda, 0, 16, 0, 8, 11, 64'h00d00000, 0);
        run("R2", 4'd1, 64'hcc, 64'h7f00ffff, 16, 1, 8, 15, 64'h7fccffff, 0);
        run("R2", 4'd1, 64'h1, 64'h7fffffff, 31, 1, 0, 0, 64'hffffffff, 0);
        run("R3 clear-left", 4'd2, 64'h0100ffff00000111, 0, 8, 1, 44, 0, 64'h11101, 0);
        run("R3 clear-right", 4'd3, 64'h0100ffffe0000111, 0, 16, 1, 0, 15, 64'hffff000000000000, 0);
        run("R4", 4'd4, 64'h0100ffff00000111, 0, 8, 1, 31, 0, 64'h11100, 0);
        run("R4", 4'd4, 64'h0100ffff00000fff, 0, 0, 1, 51, 0, 64'hfff, 0);
        run("R5 wrap", 4'd0, 64'h12345678, 0, 0, 1, 28, 3, 64'h1234567810000008, 0);
        run("R6 slw 32", 4'd5, 64'hffffffff, 0, 32, 0, 0, 0, 64'h0, 0);
        run("R6 srw", 4'd6, 64'hfffffffff0000000, 0, 4, 0, 0, 0, 64'h0f000000, 0);
        run("R7 sld 64", 4'd7, 64'hffffffffffffffff, 0, 64, 0, 0, 0, 64'h0, 0);
        run("R7 sld 0", 4'd7, 64'h8000000000000000, 0, 0, 0, 0, 0, 64'h8000000000000000, 0);
        run("R8 neg", 4'd9, 64'h82345678, 0, 8, 0, 0, 0, 64'hffffffffff823456, 1);
        run("R8 pos", 4'd9, 64'h12345678, 0, 8, 0, 0, 0, 64'h123456, 0);
        run("R8 big", 4'd9, 64'h80000000, 0, 40, 0, 0, 0, 64'hffffffffffffffff, 1);
        run("R9", 4'd10, 64'h0000010180122900, 0, 0, 1, 0, 0, 64'hffffffff80122900, 0);
        run("R9", 4'd10, 64'h5678, 0, 31, 1, 0, 0, 64'h2b3c00000000, 0);
        // R10: immediate 4 ignores rb_amt (set to 64 here)
        @(negedge clk);
        op = 4'd7; src = 64'h1; use_imm = 1'b1; imm_sh = 6'd4; rb_amt = 7'd64; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        check("R10 imm", result, 64'h10);
        run("R12 unused op", 4'd13, 64'hffffffffffffffff, 0, 3, 0, 0, 0, 64'h0, 0);
        // R11: hold and drop
        hold = result;
        @(negedge clk);
        check("R11 drop", {63'd0, out_valid}, 64'd0);
        check("R11 hold", result, hold);

        for (int k = 0; k < 400; k++) begin
            logic [3:0] o = 4'($urandom % 12);
            logic [63:0] s = {$urandom, $urandom};
            logic [63:0] t = {$urandom, $urandom};
            int n = (k % 8 == 0) ? 64 + ($urandom % 64) : ($urandom % 64);
            int b = $urandom % 64;
            int e = $urandom % 64;
            bit im = (n < 64) && ($urandom % 2 == 1);
            f_ref(o, s, t, n, b, e, er, ec);
            run($sformatf("R1-op%0d random", o), o, s, t, n, im, b, e, er, ec);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule